// File: doc/BRIEF.md
# Shared Memory Arbiter with Processor Burst Lock

This block decides, on every clock, which of four requesters may use one shared local SRAM controller. Three of the requesters are internal engines: a reassembly engine, a segmentation engine and a host-bus bridge. Each of them gets one access per grant. The fourth requester is a local processor. It has the lowest priority. Once it wins, however, no other requester can take the controller away from it until it marks the final beat of its burst.

Arbitration and data transfer overlap. The requests sampled at one rising edge decide the grant for the next cycle, while the access granted earlier is still in progress. When a processor burst ends, the arbiter inserts one cycle with no grant. During that cycle only the internal engines are considered, so any internal traffic that built up during a long burst is served first.

The processor's wait for a grant therefore depends on the internal load. It is usually a few cycles but it has no fixed upper bound. Any cycle with no internal request pending, outside the recovery cycle, hands the controller to a waiting processor.

Top module: `shared_mem_arb`

## Requirements
- R1: `gnt` is zero or one-hot at all times. `busy` is high exactly when some grant bit is high. `owner` gives the index of the granted requester, and reads 0 when nothing is granted.
- R2: A grant bit rises only for a requester whose `req` bit was high at the previous rising edge. When `req` is all zero and the processor holds no burst, `gnt` is all zero in the next cycle.
- R3: Priority is fixed by bit index: bit 0 (reassembly) beats bit 1 (segmentation), which beats bit 2 (host bridge), which beats bit 3 (processor). The winner's grant bit is high in the cycle after the edge at which the requests were sampled.
- R4: Once `gnt[3]` is high, it stays high, and no other bit rises, in every cycle until `last` is sampled high while `gnt[3]` is high. Bursts of any length complete.
- R5: The cycle after the edge at which `last` is sampled high with `gnt[3]` high has `gnt` all zero. Arbitration during that cycle excludes the processor, so the next grant goes to an internal requester or to nobody, never to bit 3.
- R6: Internal grants are re-arbitrated every cycle. An internal requester that keeps its request high and stays the highest pending one is granted in consecutive cycles.
- R7: `last` has no effect while `gnt[3]` is low.
- R8: While `rst_n` is low, `gnt` is all zero, `busy` is low and any processor lock is cleared.
- R9: A pending processor request is granted in the cycle after the first edge, outside the recovery cycle, at which no internal request is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; everything changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NREQ | Request bits; bit 0 is highest priority, bit NREQ-1 is the processor |
| last | input | 1 | Processor marks its final data beat |
| gnt | output | NREQ | Registered one-hot grant |
| busy | output | 1 | Controller is granted to someone this cycle |
| owner | output | $clog2(NREQ) | Index of the granted requester |

## Verification
The bench aims for the edges of the processor lock. A burst ends with every internal request high, which catches a design that drops the burst early (a higher bit would appear mid-burst) or that skips the recovery cycle (a grant would appear straight after the last beat). It pulses `last` while an internal engine is granted; a design that listens to it there would corrupt the next processor burst. Long runs of saturated internal traffic with single-cycle gaps check that the processor takes the first gap, since a design that starved it would never raise bit 3, and the random phase compares every cycle's grant against a reference model of the priority order.

// File: rtl/shared_mem_arb.sv
module shared_mem_arb #(
  parameter int NREQ = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREQ-1:0]         req,
  input  logic                    last,
  output logic [NREQ-1:0]         gnt,
  output logic                    busy,
  output logic [$clog2(NREQ)-1:0] owner
);
  localparam int OW  = $clog2(NREQ);
  localparam int CPU = NREQ - 1;

  logic            recov;
  logic [NREQ-1:0] cand, win;

  assign cand = recov ? (req & ~(NREQ'(1) << CPU)) : req;

  always_comb begin
    win = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (cand[i]) win = NREQ'(1) << i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt   <= '0;
      recov <= 1'b0;
    end else if (gnt[CPU] && !last) begin
      recov <= 1'b0;
    end else if (gnt[CPU]) begin
      gnt   <= '0;
      recov <= 1'b1;
    end else begin
      gnt   <= win;
      recov <= 1'b0;
    end
  end

  assign busy = |gnt;

  always_comb begin
    owner = '0;
    for (int i = 0; i < NREQ; i++)
      if (gnt[i]) owner = OW'(i);
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r2_requested: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((gnt[CPU-1:0] & ~$past(req[CPU-1:0])) == '0));

  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req[0] && !gnt[CPU])) |-> gnt[0]);

  a_r4_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[CPU] && !last) |=> gnt[CPU]);

  a_r5_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[CPU] && last) |=> (gnt == '0) ##1 !gnt[CPU]);

endmodule

// File: tb/tb_shared_mem_arb.sv
module tb_shared_mem_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         last = 1'b0;
  logic [N-1:0] gnt;
  logic         busy;
  logic [1:0]   owner;

  int vectors = 0;
  int errors  = 0;

  logic [N-1:0] m_gnt = '0;
  logic         m_rec = 1'b0;

  shared_mem_arb #(.NREQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .last(last),
    .gnt(gnt), .busy(busy), .owner(owner)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] prio(input logic [N-1:0] r, input logic no_cpu);
    logic [N-1:0] c;
    c = no_cpu ? (r & 4'b0111) : r;
    if (c[0]) return 4'b0001;
    if (c[1]) return 4'b0010;
    if (c[2]) return 4'b0100;
    if (c[3]) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic [1:0] enc(input logic [N-1:0] g);
    for (int i = 0; i < N; i++) if (g[i]) return 2'(i);
    return 2'd0;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] exp);
    vectors++;
    if (gnt !== exp) begin
      errors++;
      $display("FAIL %s gnt=%b expected %b", tag, gnt, exp);
    end
    vectors++;
    if (busy !== (|exp) || owner !== enc(exp)) begin
      errors++;
      $display("FAIL R1 busy=%b owner=%0d expected busy=%b owner=%0d",
               busy, owner, |exp, enc(exp));
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic l, input string force_tag);
    string tag;
    logic [N-1:0] nx;
    logic nrec;
    req = r; last = l;
    nrec = 1'b0;
    if (m_gnt[3] && !l) begin nx = m_gnt; tag = "R4"; end
    else if (m_gnt[3]) begin nx = '0; nrec = 1'b1; tag = "R5"; end
    else begin
      nx = prio(r, m_rec);
      if (m_rec) tag = "R5";
      else if (nx[3]) tag = "R9";
      else if (nx == '0) tag = "R2";
      else tag = "R3";
      if (l) tag = "R7";
    end
    if (force_tag != "") tag = force_tag;
    m_gnt = nx; m_rec = nrec;
    @(posedge clk);
    @(negedge clk);
    check(tag, m_gnt);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int waitc;
    int beats;
    void'($urandom(32'd1234));
    req = 4'b1111;
    repeat (3) @(negedge clk);
    check("R8", 4'b0000);
    rst_n = 1'b1;
    req = '0;

    // R2: idle
    cyc(4'b0000, 1'b0, "R2");
    // R3: priority ladder
    cyc(4'b1111, 1'b0, "R3");
    cyc(4'b1110, 1'b0, "R3");
    cyc(4'b1100, 1'b0, "R3");
    // R6: held request, back-to-back grants
    cyc(4'b0010, 1'b0, "R6");
    cyc(4'b0010, 1'b0, "R6");
    cyc(4'b0010, 1'b0, "R6");
    // R7: last while an internal engine owns
    cyc(4'b1001, 1'b1, "R7");
    cyc(4'b1000, 1'b1, "R7");
    // now processor granted (gnt=1000 after this edge? model decides)
    // R4/R5: burst of 7 beats against saturated internal traffic
    waitc = 0;
    while (!gnt[3] && waitc < 40) begin cyc(4'b1000, 1'b0, ""); waitc++; end
    vectors++;
    if (!gnt[3]) begin errors++; $display("FAIL R9 gnt=%b expected 1000", gnt); end
    beats = 1;
    while (beats < 7) begin cyc(4'b1111, 1'b0, "R4"); beats++; end
    cyc(4'b1111, 1'b1, "R5");
    cyc(4'b1111, 1'b0, "R5");
    vectors++;
    if (gnt !== 4'b0001) begin errors++; $display("FAIL R5 gnt=%b expected 0001", gnt); end

    // R9: saturated internal traffic with single-cycle gaps
    for (int g = 0; g < 20; g++) begin
      for (int k = 0; k < 5; k++) cyc(4'b1000 | 4'(1 << (k % 3)), 1'b0, "");
      waitc = 0;
      cyc(4'b1000, 1'b0, "R9");
      while (!gnt[3] && waitc < 30) begin cyc(4'b1000, 1'b0, ""); waitc++; end
      vectors++;
      if (!gnt[3]) begin errors++; $display("FAIL R9 gnt=%b expected 1000", gnt); end
      for (int b = 0; b < g % 4; b++) cyc(4'b0111, 1'b0, "R4");
      cyc(4'b0111, 1'b1, "R5");
      cyc(4'b1111, 1'b0, "R5");
    end

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] r;
      logic l;
      r = 4'($urandom);
      l = (gnt[3] ? ($urandom % 4 == 0) : ($urandom % 8 == 0));
      cyc(r, l, "");
    end

    // R8: reset in the middle of a burst
    while (!gnt[3]) cyc(4'b1000, 1'b0, "");
    #1 rst_n = 1'b0;
    #1;
    vectors++;
    if (gnt !== '0 || busy !== 1'b0) begin
      errors++; $display("FAIL R8 gnt=%b busy=%b expected 0000 0", gnt, busy);
    end
    m_gnt = '0; m_rec = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(4'b0100, 1'b0, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule